// File: doc/BRIEF.md
# Multi-lane bit-slip word aligner

This block takes the parallel words produced by a deserializer on each of several receive lanes and moves the word boundary so that a chosen bit of the serial stream lands in the least significant bit of every output word. Each lane keeps a slip position between 0 and W-1, where W is the internal word width. That position selects a W-bit window out of the concatenation of the word arriving now and the word that arrived one cycle earlier. The selected window is registered and driven out.

An alignment controller outside the block watches the output for a known pattern. Each time the pattern is missing, it pulses that lane's slip input. The slip input may come from another clock domain, so the block passes it through a synchronizer and then acts on its rising edge only. A slip input held high gives one advance, not several. The position of every lane can be read through a small 16-bit read port. This lets software or a monitoring engine confirm where each lane has locked.

Each lane has its own reset, which clears that lane's position and stored data without affecting the other lanes. The read port has its own reset.

Top module: `bitslip_aligner`

## Requirements
- R1: Asserting `lane_rst[n]` clears lane n's slip position to 0, clears its output word to 0, and clears its stored previous word to 0. As a result, with position 0 the first word received after reset produces an all-zero output.
- R2: Each rising edge of `slip_in[n]`, after synchronization, advances lane n's position by exactly one. A slip input held high for many cycles advances the position only once.
- R3: The position wraps from W-1 back to 0 on the next slip.
- R4: Each cycle, the output word of lane n equals bits [pos +: W] of {word sampled at this clock edge, word sampled at the previous edge}. It is registered, so it is visible after the edge that samples the current word.
- R5: A read of address 0x500E + 0x100*n returns lane n's position in bits [4:0], with bits [15:5] reading as zero. Address bits [9:8] select the lane.
- R6: A read of any address that matches no lane register returns 0x0000.
- R7: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and low otherwise. `rd_data` holds the read result during that cycle.
- R8: Resetting one lane, or slipping one lane, leaves the positions of the other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all lanes and the read port |
| rst | input | 1 | Synchronous active-high reset of the read port |
| lane_rst | input | LANES | Synchronous active-high reset, one bit per lane |
| slip_in | input | LANES | Slip request, one bit per lane; may be asynchronous |
| rx_word_in | input | LANES*WORD_W | Deserialized words, lane n in slice [n*WORD_W +: WORD_W] |
| rx_word_out | output | LANES*WORD_W | Aligned words, same lane packing |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read address |
| rd_data | output | 16 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High one cycle after `rd_en` |

## Verification
On every cycle, the assertions check the following. A synchronized slip produces a single-cycle pulse. The position holds still when there is no pulse, wraps to zero from W-1, and never leaves the word window. The read valid flag tracks the read strobe with one cycle of delay. Reserved readback bits stay zero, and unmatched addresses read zero. Other properties depend on sequences of stimulus and can only be shown by the bench scenarios: the exact window chosen for specific data pairs at many positions, the single advance from a slip held high, wrap after many slips, and the independence of per-lane reset and slip.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  localparam int unsigned POS_W  = 5;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] POS_REG_BASE  = 16'h500E;
  localparam logic [ADDR_W-1:0] LANE_SEL_MASK = 16'h0300;
  localparam int unsigned LANE_SEL_LSB = 8;
  localparam int unsigned MAX_LANES    = 4;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/slip_sync_edge.sv
module slip_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slip_async,
  output logic slip_pulse
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], slip_async};
      last_q <= sync_q[TOP];
    end
  end

  assign slip_pulse = sync_q[TOP] & ~last_q;

  // R2: a held level yields one pulse only
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/slip_pos_ctr.sv
module slip_pos_ctr
  import bitslip_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output pos_t pos
);
  localparam pos_t LAST_POS = pos_t'(WORD_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step) begin
      pos <= (pos == LAST_POS) ? '0 : pos + pos_t'(1);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && pos == LAST_POS) |=> pos == '0);
  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS);
endmodule

// File: rtl/word_window.sv
module word_window
  import bitslip_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  pos_t              pos,
  output logic [WORD_W-1:0] word_out
);
  localparam int unsigned WIN_W = 2 * WORD_W;

  logic [WORD_W-1:0] prev_q;
  logic [WIN_W-1:0]  win_shifted;

  assign win_shifted = {word_in, prev_q} >> pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      word_out <= '0;
    end else begin
      prev_q   <= word_in;
      word_out <= win_shifted[WORD_W-1:0];
    end
  end

  // R4: window start stays inside the two-word span
  p_window_in_span_r4: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < WORD_W);
endmodule

// File: rtl/bitslip_lane.sv
module bitslip_lane
  import bitslip_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slip_async,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output pos_t              pos
);
  logic step;

  slip_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .slip_async(slip_async), .slip_pulse(step)
  );

  slip_pos_ctr #(.WORD_W(WORD_W)) i_ctr (
    .clk(clk), .rst(rst), .step(step), .pos(pos)
  );

  word_window #(.WORD_W(WORD_W)) i_win (
    .clk(clk), .rst(rst), .word_in(word_in), .pos(pos), .word_out(word_out)
  );
endmodule

// File: rtl/lane_status_rd.sv
module lane_status_rd
  import bitslip_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  addr_t                rd_addr,
  input  logic [LANES*POS_W-1:0] pos_flat,
  output reg_t                 rd_data,
  output logic                 rd_valid
);
  logic       base_hit;
  logic [2:0] lane_idx;
  pos_t       sel_pos;

  assign base_hit = ((rd_addr & ~LANE_SEL_MASK) == POS_REG_BASE);
  assign lane_idx = {1'b0, rd_addr[LANE_SEL_LSB +: 2]};

  always_comb begin
    sel_pos = '0;
    for (int i = 0; i < LANES; i++) begin
      if (base_hit && lane_idx == 3'(i)) sel_pos = pos_flat[i*POS_W +: POS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= reg_t'(sel_pos);
    end
  end

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[REG_W-1:POS_W] == '0);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !base_hit) |=> rd_data == '0);
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bitslip_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          lane_rst,
  input  logic [LANES-1:0]          slip_in,
  input  logic [LANES*WORD_W-1:0]   rx_word_in,
  output logic [LANES*WORD_W-1:0]   rx_word_out,
  input  logic                      rd_en,
  input  logic [15:0]               rd_addr,
  output logic [15:0]               rd_data,
  output logic                      rd_valid
);
  logic [LANES*POS_W-1:0] pos_flat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pos_t lane_pos;
    bitslip_lane #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) i_lane (
      .clk       (clk),
      .rst       (lane_rst[g]),
      .slip_async(slip_in[g]),
      .word_in   (rx_word_in[g*WORD_W +: WORD_W]),
      .word_out  (rx_word_out[g*WORD_W +: WORD_W]),
      .pos       (lane_pos)
    );
    assign pos_flat[g*POS_W +: POS_W] = lane_pos;
  end

  lane_status_rd #(.LANES(LANES)) i_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .pos_flat(pos_flat),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );
endmodule

// File: tb/test_bitslip_aligner.sv
module test_bitslip_aligner;
  localparam int LANES = 4;
  localparam int W     = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [LANES-1:0]  lane_rst;
  logic [LANES-1:0]  slip_in;
  logic [LANES*W-1:0] rx_word_in;
  logic [LANES*W-1:0] rx_word_out;
  logic              rd_en;
  logic [15:0]       rd_addr;
  logic [15:0]       rd_data;
  logic              rd_valid;

  int checks = 0;
  int errors = 0;
  int model_pos [LANES];
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitslip_aligner #(.LANES(LANES), .WORD_W(W)) i_bitslip_aligner (
    .clk(clk), .rst(rst), .lane_rst(lane_rst), .slip_in(slip_in),
    .rx_word_in(rx_word_in), .rx_word_out(rx_word_out),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {lane[1:0], slips[4:0], first word[15:0], second word[15:0]}
  localparam logic [38:0] VEC [8] = '{
    {2'd0, 5'd0,  16'h1234, 16'hABCD},
    {2'd0, 5'd1,  16'hF00F, 16'h0FF0},
    {2'd0, 5'd3,  16'hA5A5, 16'h5A5A},
    {2'd1, 5'd7,  16'h8001, 16'h7FFE},
    {2'd2, 5'd15, 16'hFFFF, 16'h0000},
    {2'd3, 5'd5,  16'hC3C3, 16'h3C3C},
    {2'd1, 5'd8,  16'h1357, 16'h2468},
    {2'd0, 5'd12, 16'h0F1E, 16'h2D3C}
  };

  function automatic logic [W-1:0] window(logic [W-1:0] cur, logic [W-1:0] prv, int p);
    logic [2*W-1:0] cat;
    cat = {cur, prv};
    return cat[p +: W];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slip_once(int lane);
    @(negedge clk); slip_in[lane] = 1'b1;
    repeat (3) @(negedge clk);
    slip_in[lane] = 1'b0;
    repeat (3) @(negedge clk);
    model_pos[lane] = (model_pos[lane] + 1) % W;
  endtask

  task automatic do_read(logic [15:0] addr, output logic [15:0] data, output logic vld);
    @(negedge clk); rd_en = 1'b1; rd_addr = addr;
    @(negedge clk); rd_en = 1'b0;
    data = rd_data; vld = rd_valid;
  endtask

  task automatic check_pos(string req, int lane);
    logic [15:0] d; logic v;
    do_read(16'h500E + 16'(lane) * 16'h0100, d, v);
    check(req, {31'd0, v}, 32'd1);
    check(req, {16'd0, d}, 32'(model_pos[lane]));
  endtask

  task automatic check_window(string req, int lane, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk); rx_word_in[lane*W +: W] = a;
    @(negedge clk); rx_word_in[lane*W +: W] = b;
    @(negedge clk);
    check(req, {16'd0, rx_word_out[lane*W +: W]}, {16'd0, window(b, a, model_pos[lane])});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic v;
    rst = 1'b1; lane_rst = '1; slip_in = '0; rx_word_in = '0;
    rd_en = 1'b0; rd_addr = '0;
    for (int i = 0; i < LANES; i++) model_pos[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0; lane_rst = '0;

    // R1 reset state, R5 readback addresses
    check("R1", {32'd0} | rx_word_out[31:0], 32'd0);
    for (int i = 0; i < LANES; i++) check_pos("R1 R5", i);

    // table-driven window and position checks (R2 R3 R4 R5)
    for (int k = 0; k < 8; k++) begin
      int lane; int n;
      lane = int'(VEC[k][38:37]);
      n    = int'(VEC[k][36:32]);
      for (int s = 0; s < n; s++) slip_once(lane);
      repeat (2) @(negedge clk);
      check_pos("R2 R3 R5", lane);
      check_window("R4", lane, VEC[k][31:16], VEC[k][15:0]);
    end

    // R3: lane0 has wrapped to 0 (4 + 12 slips)
    check("R3", 32'(model_pos[0]), 32'd0);

    // R2: slip held high advances once
    @(negedge clk); slip_in[2] = 1'b1;
    repeat (12) @(negedge clk);
    slip_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    model_pos[2] = (model_pos[2] + 1) % W;
    check_pos("R2 held", 2);

    // R8: other lanes unaffected by lane 2 slip
    check_pos("R8", 1);
    check_pos("R8", 3);

    // R6: unmatched addresses
    do_read(16'h500F, d, v); check("R6", {16'd0, d}, 32'd0);
    do_read(16'h540E, d, v); check("R6", {16'd0, d}, 32'd0);
    do_read(16'h0000, d, v); check("R6", {16'd0, d}, 32'd0);
    do_read(16'h510D, d, v); check("R6", {16'd0, d}, 32'd0);

    // R7: valid drops the cycle after a lone read
    @(negedge clk); check("R7", {31'd0, rd_valid}, 32'd0);

    // R1 / R8: reset lane 1 only
    @(negedge clk); lane_rst[1] = 1'b1; rx_word_in[W +: W] = 16'h9999;
    @(negedge clk); lane_rst[1] = 1'b0; rx_word_in[W +: W] = 16'hBEEF;
    model_pos[1] = 0;
    check("R1 out", {16'd0, rx_word_out[W +: W]}, 32'd0);
    @(negedge clk);
    check("R1 prev", {16'd0, rx_word_out[W +: W]}, 32'd0);
    check_pos("R1", 1);
    check_pos("R8", 3);
    check_pos("R8", 2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule